// File: doc/BRIEF.md
# Parallel Code-Memory Programming Sequencer

This block runs on the host side of a parallel-mode code-memory target. It powers the target up in a fixed order and takes image bytes from a valid/ready byte stream. Each byte is written with a high-voltage strobe cycle. The block waits until the target reports that the write is complete. It then resets the target's internal address and reads the whole image back. The read-back data is compared with a second copy of the same image, which arrives on the same stream. At the end it powers the target down in the reverse order. It reports completion, a sticky error flag, the failing address and the failing byte.

The target has no address pins. The sequencer moves through memory only by pulsing an address-advance line, and it returns to address zero only by taking the target enable low and then high again. The `USE_POLL` parameter picks how write completion is detected:

- With `USE_POLL` = 0, the block watches a ready/busy input.
- With `USE_POLL` = 1, the block reads the target back and compares bit 7 of the returned byte with bit 7 of the byte that was written.

A timeout bounds every write. Its default is four times the nominal 1.2 ms write time, counted at 50 MHz.

Each step of the sequence is held for `STEP_CYC` clock cycles. The states, in order, are:

- `S_IDLE`, then `start` leads to `S_PWR` (supply on).
- `S_RSTHI` raises the enable and the strobe line.
- The write loop: `S_WSEL` (select write mode), `S_WLOAD` (wait for a byte), `S_WDATA` (drive data), `S_WHV` (high voltage on), `S_WSTB` (strobe low), `S_WWAIT` (wait for completion). After `S_WWAIT`, the block goes to `S_WADV` (advance pulse, then back to `S_WSEL`) or, after the last byte, to `S_VRST0`.
- The address reset: `S_VRST0` (enable low), then `S_VRST1` (enable high).
- The verify loop: `S_VSEL` (select read mode), `S_VLOAD` (wait for a byte), `S_VSAMP` (sample and compare). After `S_VSAMP`, the block goes to `S_VADV` (advance pulse, then back to `S_VLOAD`) or, after the last byte, to `S_OFF_ADV`.
- The power-down: `S_OFF_ADV`, then `S_OFF_RST`, then `S_DONE`.
- A timeout in `S_WWAIT` or a mismatch in `S_VSAMP` jumps straight to `S_OFF_ADV`.
- A new `start` in `S_DONE` re-enters `S_PWR`.

Top module: `prog_seq_top`

## Requirements
- R1: After reset, and in idle, every target output is low: supply, enable, high voltage, advance, strobe, data enable and mode (4'h0). `done` is low after reset.
- R2: On `start`, supply turns on with enable, advance and strobe low for `STEP_CYC` cycles. Enable and strobe then rise together, and enable never rises while supply is off.
- R3: For each byte, the mode lines show write (4'hE) before data is driven. Data is driven before high voltage rises. The strobe is pulsed low exactly once while high voltage is on. High voltage is only ever on with enable high, write mode and data driven.
- R4: In busy mode, after the strobe the block drops high voltage, selects read mode (4'hC) and ignores `tgt_rdy` for `STEP_CYC` cycles. The write is complete once `tgt_rdy` is high.
- R5: In polling mode, the write is complete once bit 7 of `tgt_dq_in` equals bit 7 of the byte written.
- R6: If a write is not complete within `TIMEOUT_CYC` cycles of the strobe, the sequence stops. `error` is set, `err_addr` holds the byte index and `err_data` holds the byte being written.
- R7: The advance line is pulsed once between consecutive bytes and never after the last byte of a pass.
- R8: A pass ends at the byte flagged by `s_last`, or after `DEPTH` bytes, whichever comes first.
- R9: After writing, the enable goes low and then high. Each byte is then read in mode 4'hC and compared with the next stream byte, which is the second copy of the image.
- R10: On a verify mismatch the sequence stops. `error` is set, `err_addr` holds the index and `err_data` holds the byte read back.
- R11: Power-down drops advance and high voltage first, then enable and strobe, then supply. `done` stays high until the next `start`, and `error` stays set until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program-and-verify run (accepted in idle or done) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of this copy of the image |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| tgt_pwr | output | 1 | Target supply enable |
| tgt_rst | output | 1 | Target reset/enable |
| tgt_hv | output | 1 | High-voltage enable on the reset/enable line |
| tgt_adv | output | 1 | Address-advance pulse |
| tgt_prog | output | 1 | Program strobe (idles high once enabled, pulses low) |
| tgt_mode | output | 4 | Operation select (4'hE write, 4'hC read, 4'h0 idle) |
| tgt_dq_out | output | 8 | Data driven to the target |
| tgt_dq_oe | output | 1 | Data drive enable |
| tgt_dq_in | input | 8 | Data read from the target |
| tgt_rdy | input | 1 | Target ready (high) / busy (low) |
| done | output | 1 | Run finished and target powered off |
| error | output | 1 | Run failed (timeout or mismatch) |
| err_addr | output | $clog2(DEPTH) | Byte index of the failure |
| err_data | output | 8 | Written byte on timeout, read-back byte on mismatch |

## Verification
The main function is tried with several image shapes:

- A five-byte image, which proves that the written contents match and that the bytes past the end stay erased.
- A one-byte image, which separates "no advance after the last byte" from an off-by-one in the advance count.
- An image without any end flag, which shows that the depth limit alone ends both passes.

The error paths are covered by two further patterns. A verify copy with one altered byte must be caught at that exact index, with the target's byte reported. A target that never finishes one address must produce a timeout naming that address and the byte being written. A second instance in polling mode runs an image whose bytes have both values of bit 7, so a completion test fixed at either polarity would fail. On every clock, the pin rules for supply, enable and high voltage are checked on both instances.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PWR,
        S_RSTHI,
        S_WSEL,
        S_WLOAD,
        S_WDATA,
        S_WHV,
        S_WSTB,
        S_WWAIT,
        S_WADV,
        S_VRST0,
        S_VRST1,
        S_VSEL,
        S_VLOAD,
        S_VSAMP,
        S_VADV,
        S_OFF_ADV,
        S_OFF_RST,
        S_DONE
    } seq_state_t;

    localparam logic [3:0] MODE_IDLE  = 4'h0;
    localparam logic [3:0] MODE_WRITE = 4'hE;
    localparam logic [3:0] MODE_READ  = 4'hC;

endpackage

// File: rtl/prog_seq_cnt.sv
module prog_seq_cnt #(
    parameter int W   = 4,
    parameter int MAX = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && q != LIMIT) begin
            q <= q + 1'b1;
        end
    end

    // R8 / R6: the counter saturates and never passes its limit
    p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q <= LIMIT);

endmodule

// File: rtl/prog_seq_done_det.sv
module prog_seq_done_det #(
    parameter int USE_POLL = 0
) (
    input  logic armed,
    input  logic rdy,
    input  logic rd_bit7,
    input  logic wr_bit7,
    output logic fin
);
    generate
        if (USE_POLL != 0) begin : g_poll
            assign fin = armed && (rd_bit7 == wr_bit7);
        end else begin : g_busy
            assign fin = armed && rdy;
        end
    endgenerate
endmodule

// File: rtl/prog_seq_top.sv
module prog_seq_top
    import prog_seq_pkg::*;
#(
    parameter int DEPTH       = 4096,
    parameter int USE_POLL    = 0,
    parameter int STEP_CYC    = 8,
    parameter int TIMEOUT_CYC = 240000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     s_valid,
    input  logic [7:0]               s_data,
    input  logic                     s_last,
    output logic                     s_ready,
    output logic                     tgt_pwr,
    output logic                     tgt_rst,
    output logic                     tgt_hv,
    output logic                     tgt_adv,
    output logic                     tgt_prog,
    output logic [3:0]               tgt_mode,
    output logic [7:0]               tgt_dq_out,
    output logic                     tgt_dq_oe,
    input  logic [7:0]               tgt_dq_in,
    input  logic                     tgt_rdy,
    output logic                     done,
    output logic                     error,
    output logic [$clog2(DEPTH)-1:0] err_addr,
    output logic [7:0]               err_data
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int STEP_W = $clog2(STEP_CYC + 1);
    localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

    seq_state_t state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic [TO_W-1:0]   wait_q;
    logic [ADDR_W-1:0] idx_q;
    logic [7:0]        byte_q;
    logic              last_q;
    logic              err_q;
    logic [ADDR_W-1:0] err_addr_q;
    logic [7:0]        err_data_q;
    logic              step_done, timeout, armed, wr_fin, accept, mismatch;

    prog_seq_cnt #(.W(STEP_W), .MAX(STEP_CYC)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .inc(1'b1), .q(step_q));

    prog_seq_cnt #(.W(TO_W), .MAX(TIMEOUT_CYC)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr(state_q != S_WWAIT), .inc(1'b1), .q(wait_q));

    prog_seq_cnt #(.W(ADDR_W), .MAX(DEPTH - 1)) u_idx (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == S_PWR || state_q == S_VRST0),
        .inc((state_q == S_WADV || state_q == S_VADV) && step_done),
        .q(idx_q));

    assign step_done = (step_q == STEP_W'(STEP_CYC - 1));
    assign timeout   = (wait_q == TO_W'(TIMEOUT_CYC - 1));
    assign armed     = (wait_q >= TO_W'(STEP_CYC));
    assign accept    = s_valid && s_ready;
    assign mismatch  = (tgt_dq_in != byte_q);

    prog_seq_done_det #(.USE_POLL(USE_POLL)) u_det (
        .armed(armed), .rdy(tgt_rdy), .rd_bit7(tgt_dq_in[7]),
        .wr_bit7(byte_q[7]), .fin(wr_fin));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_PWR;
            S_PWR:     if (step_done) state_d = S_RSTHI;
            S_RSTHI:   if (step_done) state_d = S_WSEL;
            S_WSEL:    if (step_done) state_d = S_WLOAD;
            S_WLOAD:   if (s_valid) state_d = S_WDATA;
            S_WDATA:   if (step_done) state_d = S_WHV;
            S_WHV:     if (step_done) state_d = S_WSTB;
            S_WSTB:    if (step_done) state_d = S_WWAIT;
            S_WWAIT: begin
                if (timeout)     state_d = S_OFF_ADV;
                else if (wr_fin) state_d = last_q ? S_VRST0 : S_WADV;
            end
            S_WADV:    if (step_done) state_d = S_WSEL;
            S_VRST0:   if (step_done) state_d = S_VRST1;
            S_VRST1:   if (step_done) state_d = S_VSEL;
            S_VSEL:    if (step_done) state_d = S_VLOAD;
            S_VLOAD:   if (s_valid) state_d = S_VSAMP;
            S_VSAMP: begin
                if (step_done) state_d = (mismatch || last_q) ? S_OFF_ADV : S_VADV;
            end
            S_VADV:    if (step_done) state_d = S_VLOAD;
            S_OFF_ADV: if (step_done) state_d = S_OFF_RST;
            S_OFF_RST: if (step_done) state_d = S_DONE;
            S_DONE:    if (start) state_d = S_PWR;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // data path and error capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q     <= '0;
            last_q     <= 1'b0;
            err_q      <= 1'b0;
            err_addr_q <= '0;
            err_data_q <= '0;
        end else begin
            if (accept) begin
                byte_q <= s_data;
                last_q <= s_last || (idx_q == ADDR_W'(DEPTH - 1));
            end
            if ((state_q == S_IDLE || state_q == S_DONE) && start) begin
                err_q <= 1'b0;
            end else if (state_q == S_WWAIT && timeout) begin
                err_q      <= 1'b1;
                err_addr_q <= idx_q;
                err_data_q <= byte_q;
            end else if (state_q == S_VSAMP && step_done && mismatch) begin
                err_q      <= 1'b1;
                err_addr_q <= idx_q;
                err_data_q <= tgt_dq_in;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        tgt_pwr   = 1'b0;
        tgt_rst   = 1'b0;
        tgt_hv    = 1'b0;
        tgt_adv   = 1'b0;
        tgt_prog  = 1'b0;
        tgt_mode  = MODE_IDLE;
        tgt_dq_oe = 1'b0;
        s_ready   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PWR:  tgt_pwr = 1'b1;
            S_RSTHI, S_VRST1, S_OFF_ADV: begin
                tgt_pwr = 1'b1; tgt_rst = 1'b1; tgt_prog = 1'b1;
            end
            S_WSEL, S_WLOAD: begin
                tgt_pwr = 1'b1; tgt_rst = 1'b1; tgt_prog = 1'b1;
                tgt_mode = MODE_WRITE;
                s_ready = (state_q == S_WLOAD);
            end
            S_WDATA, S_WHV, S_WSTB: begin
                tgt_pwr = 1'b1; tgt_rst = 1'b1; tgt_mode = MODE_WRITE;
                tgt_dq_oe = 1'b1;
                tgt_hv   = (state_q != S_WDATA);
                tgt_prog = (state_q != S_WSTB);
            end
            S_WWAIT, S_WADV, S_VSEL, S_VLOAD, S_VSAMP, S_VADV: begin
                tgt_pwr = 1'b1; tgt_rst = 1'b1; tgt_prog = 1'b1;
                tgt_mode = MODE_READ;
                tgt_adv = (state_q == S_WADV || state_q == S_VADV);
                s_ready = (state_q == S_VLOAD);
            end
            S_VRST0: begin
                tgt_pwr = 1'b1; tgt_prog = 1'b1; tgt_mode = MODE_READ;
            end
            S_OFF_RST: tgt_pwr = 1'b1;
            S_DONE:    done = 1'b1;
            default: ;
        endcase
    end

    assign tgt_dq_out = byte_q;
    assign error      = err_q;
    assign err_addr   = err_addr_q;
    assign err_data   = err_data_q;

    // R2: enable rises only after supply was already on
    p_rst_after_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst) |-> tgt_pwr && $past(tgt_pwr));

    // R11: supply falls only after enable was already low
    p_pwr_off_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_pwr) |-> !tgt_rst && !$past(tgt_rst) && !$past(tgt_adv));

    // R11: error stays set until a new run starts
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error);

    // R3: high voltage never rises without data already driven
    p_hv_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_hv) |-> $past(tgt_dq_oe));

    // R11: done only with target unpowered
    p_done_unpowered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tgt_pwr);

endmodule

// File: tb/prog_target_env.sv
module prog_target_env #(
    parameter int WR_CYC = 20
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       stuck_en,
    input  logic [3:0] stuck_addr,
    input  int         len,
    input  logic       has_last,
    output logic       s_valid,
    output logic [7:0] s_data,
    output logic       s_last,
    input  logic       s_ready,
    input  logic       pwr,
    input  logic       rst,
    input  logic       hv,
    input  logic       adv,
    input  logic       prog,
    input  logic [3:0] mode,
    input  logic [7:0] dq,
    output logic [7:0] dq_in,
    output logic       rdy,
    output int         n_writes,
    output int         n_adv,
    output int         n_rst
);
    logic [7:0] mem  [16];
    logic [7:0] img  [16];
    logic [7:0] vimg [16];
    logic [3:0] addr, waddr;
    logic [7:0] wdat;
    logic       busy, p_rst, p_adv, p_prog;
    int         bcnt, idx;

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'hFF;
            addr <= '0; waddr <= '0; wdat <= '0; busy <= 1'b0; bcnt <= 0;
            idx <= 0; n_writes <= 0; n_adv <= 0; n_rst <= 0;
            p_rst <= 1'b0; p_adv <= 1'b0; p_prog <= 1'b0;
        end else begin
            p_rst <= rst; p_adv <= adv; p_prog <= prog;
            if (rst && !p_rst) begin
                addr <= '0; n_rst <= n_rst + 1;
            end else if (adv && !p_adv) begin
                addr <= addr + 1'b1; n_adv <= n_adv + 1;
            end
            if (!prog && p_prog && hv && mode == 4'hE) begin
                busy <= 1'b1; bcnt <= WR_CYC; wdat <= dq; waddr <= addr;
                n_writes <= n_writes + 1;
            end else if (busy && !(stuck_en && waddr == stuck_addr)) begin
                if (bcnt == 0) begin
                    mem[waddr] <= wdat; busy <= 1'b0;
                end else begin
                    bcnt <= bcnt - 1;
                end
            end
            if (s_valid && s_ready) idx <= idx + 1;
        end
    end

    always_comb begin
        rdy   = !busy;
        dq_in = 8'h00;
        if (pwr && rst && !hv && mode == 4'hC)
            dq_in = busy ? {~wdat[7], wdat[6:0]} : mem[addr];
        s_valid = !clr && (idx < 2 * len);
        s_data  = (idx < len) ? img[4'(idx)] : vimg[4'(idx - len)];
        s_last  = has_last && (idx == len - 1 || idx == 2 * len - 1);
    end
endmodule

// File: tb/prog_seq_top_tb.sv
module prog_seq_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    // instance A: busy pin; instance B: polling
    logic start_a = 1'b0, start_b = 1'b0;
    logic clr_a = 1'b1, clr_b = 1'b1;
    logic stuck_a = 1'b0;
    logic [3:0] stuck_addr_a = 4'd0;
    int len_a = 0, len_b = 0;
    logic last_a = 1'b1;

    logic sv_a, sl_a, sr_a, pwr_a, rst_a, hv_a, adv_a, prog_a, oe_a, rdy_a, done_a, err_a;
    logic [7:0] sd_a, dqo_a, dqi_a, ed_a;
    logic [3:0] mode_a;
    logic [2:0] ea_a;
    int nw_a, na_a, nr_a;

    logic sv_b, sl_b, sr_b, pwr_b, rst_b, hv_b, adv_b, prog_b, oe_b, rdy_b, done_b, err_b;
    logic [7:0] sd_b, dqo_b, dqi_b, ed_b;
    logic [3:0] mode_b;
    logic [2:0] ea_b;
    int nw_b, na_b, nr_b;

    prog_seq_top #(.DEPTH(8), .USE_POLL(0), .STEP_CYC(4), .TIMEOUT_CYC(100)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start_a), .s_valid(sv_a), .s_data(sd_a),
        .s_last(sl_a), .s_ready(sr_a), .tgt_pwr(pwr_a), .tgt_rst(rst_a), .tgt_hv(hv_a),
        .tgt_adv(adv_a), .tgt_prog(prog_a), .tgt_mode(mode_a), .tgt_dq_out(dqo_a),
        .tgt_dq_oe(oe_a), .tgt_dq_in(dqi_a), .tgt_rdy(rdy_a), .done(done_a),
        .error(err_a), .err_addr(ea_a), .err_data(ed_a));

    prog_target_env u_env_a (
        .clk(clk), .clr(clr_a), .stuck_en(stuck_a), .stuck_addr(stuck_addr_a),
        .len(len_a), .has_last(last_a), .s_valid(sv_a), .s_data(sd_a), .s_last(sl_a),
        .s_ready(sr_a), .pwr(pwr_a), .rst(rst_a), .hv(hv_a), .adv(adv_a), .prog(prog_a),
        .mode(mode_a), .dq(dqo_a), .dq_in(dqi_a), .rdy(rdy_a),
        .n_writes(nw_a), .n_adv(na_a), .n_rst(nr_a));

    prog_seq_top #(.DEPTH(8), .USE_POLL(1), .STEP_CYC(4), .TIMEOUT_CYC(100)) u_dut_poll (
        .clk(clk), .rst_n(rst_n), .start(start_b), .s_valid(sv_b), .s_data(sd_b),
        .s_last(sl_b), .s_ready(sr_b), .tgt_pwr(pwr_b), .tgt_rst(rst_b), .tgt_hv(hv_b),
        .tgt_adv(adv_b), .tgt_prog(prog_b), .tgt_mode(mode_b), .tgt_dq_out(dqo_b),
        .tgt_dq_oe(oe_b), .tgt_dq_in(dqi_b), .tgt_rdy(rdy_b), .done(done_b),
        .error(err_b), .err_addr(ea_b), .err_data(ed_b));

    prog_target_env u_env_b (
        .clk(clk), .clr(clr_b), .stuck_en(1'b0), .stuck_addr(4'd0),
        .len(len_b), .has_last(1'b1), .s_valid(sv_b), .s_data(sd_b), .s_last(sl_b),
        .s_ready(sr_b), .pwr(pwr_b), .rst(rst_b), .hv(hv_b), .adv(adv_b), .prog(prog_b),
        .mode(mode_b), .dq(dqo_b), .dq_in(dqi_b), .rdy(rdy_b),
        .n_writes(nw_b), .n_adv(na_b), .n_rst(nr_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            finish_run();
        end
    end

    // per-clock pin rules on both instances
    logic pp_pwr_a = 1'b0, pp_rst_a = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!pwr_a) chk({rst_a, hv_a, adv_a, prog_a, oe_a} == 5'b0, "R11 A unpowered pins",
                            {rst_a, hv_a, adv_a, prog_a, oe_a}, 0);
            if (!pwr_b) chk({rst_b, hv_b, adv_b, prog_b, oe_b} == 5'b0, "R11 B unpowered pins",
                            {rst_b, hv_b, adv_b, prog_b, oe_b}, 0);
            if (hv_a) chk(rst_a && oe_a && mode_a == 4'hE, "R3 A hv context",
                          {rst_a, oe_a, mode_a}, 6'h3E);
            if (hv_b) chk(rst_b && oe_b && mode_b == 4'hE, "R3 B hv context",
                          {rst_b, oe_b, mode_b}, 6'h3E);
            if (rst_a && !pp_rst_a) chk(pp_pwr_a && prog_a, "R2 A enable after supply",
                                        {pp_pwr_a, prog_a}, 3);
            pp_pwr_a = pwr_a;
            pp_rst_a = rst_a;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 90);
    endfunction

    task automatic load_a(input int n, input logic lst, input int bad);
        @(negedge clk);
        clr_a = 1'b1; len_a = n; last_a = lst;
        for (int i = 0; i < 16; i++) begin
            u_env_a.img[i]  = pat(i);
            u_env_a.vimg[i] = (i == bad) ? (pat(i) ^ 8'h10) : pat(i);
        end
        @(negedge clk);
        clr_a = 1'b0;
    endtask

    task automatic run_a();
        @(negedge clk); start_a = 1'b1;
        @(negedge clk); start_a = 1'b0;
        while (!done_a) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            u_env_a.img[i] = 8'h00; u_env_a.vimg[i] = 8'h00;
            u_env_b.img[i] = pat(i); u_env_b.vimg[i] = pat(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({pwr_a, rst_a, hv_a, adv_a, prog_a, oe_a, done_a, err_a} == 8'b0 && mode_a == 4'h0,
            "R1 reset outputs", {pwr_a, rst_a, hv_a, adv_a, prog_a, oe_a, done_a, err_a, mode_a}, 0);
        clr_a = 1'b0; clr_b = 1'b0;

        // five-byte image, good verify
        load_a(5, 1'b1, -1);
        run_a();
        chk(!err_a, "R9 clean run no error", err_a, 0);
        for (int i = 0; i < 5; i++)
            chk(u_env_a.mem[i] == pat(i), "R3 byte written", u_env_a.mem[i], pat(i));
        chk(u_env_a.mem[5] == 8'hFF, "R8 stop at s_last", u_env_a.mem[5], 8'hFF);
        chk(nw_a == 5, "R3 one strobe per byte", nw_a, 5);
        chk(na_a == 8, "R7 advance pulses", na_a, 8);
        chk(nr_a == 2, "R9 address reset before verify", nr_a, 2);
        chk(!pwr_a && done_a, "R11 powered down and done", {pwr_a, done_a}, 1);
        repeat (10) @(negedge clk);
        chk(done_a, "R11 done held", done_a, 1);

        // verify mismatch at index 2
        load_a(4, 1'b1, 2);
        run_a();
        chk(err_a, "R10 mismatch flagged", err_a, 1);
        chk(ea_a == 3'd2, "R10 failing address", ea_a, 2);
        chk(ed_a == pat(2), "R10 read-back byte", ed_a, pat(2));
        chk(na_a == 5, "R10 stop at mismatch", na_a, 5);

        // write never finishes at address 1
        stuck_a = 1'b1; stuck_addr_a = 4'd1;
        load_a(4, 1'b1, -1);
        run_a();
        chk(err_a, "R6 timeout flagged", err_a, 1);
        chk(ea_a == 3'd1, "R6 timeout address", ea_a, 1);
        chk(ed_a == pat(1), "R6 timeout byte", ed_a, pat(1));
        chk(nw_a == 2 && nr_a == 1, "R6 sequence stopped", {nw_a[7:0], nr_a[7:0]}, 16'h0201);
        stuck_a = 1'b0;

        // no end flag: depth limit ends each pass
        load_a(8, 1'b0, -1);
        run_a();
        chk(!err_a, "R8 depth limit run clean", err_a, 0);
        chk(nw_a == 8, "R8 depth limit writes", nw_a, 8);
        chk(na_a == 14, "R8 depth limit advances", na_a, 14);
        chk(u_env_a.mem[7] == pat(7), "R8 last byte at depth", u_env_a.mem[7], pat(7));

        // single-byte image
        load_a(1, 1'b1, -1);
        run_a();
        chk(!err_a && nw_a == 1, "R7 single byte written", {err_a, nw_a[7:0]}, 1);
        chk(na_a == 0, "R7 no advance after last byte", na_a, 0);
        chk(!err_a, "R4 busy completion error clear", err_a, 0);

        // polling instance, bytes with both bit-7 values
        @(negedge clk); clr_b = 1'b1; len_b = 3;
        @(negedge clk); clr_b = 1'b0;
        @(negedge clk); start_b = 1'b1;
        @(negedge clk); start_b = 1'b0;
        while (!done_b) @(negedge clk);
        chk(!err_b, "R5 polling run no error", err_b, 0);
        for (int i = 0; i < 3; i++)
            chk(u_env_b.mem[i] == pat(i), "R5 polled byte written", u_env_b.mem[i], pat(i));
        chk(nw_b == 3 && na_b == 4, "R5 polling sequence", {nw_b[7:0], na_b[7:0]}, 16'h0304);

        finish_run();
    end
endmodule